// File: doc/BRIEF.md
# Audio Coprocessor Register Decoder

This block sits on the 8-bit data, 16-bit address bus of a small audio coprocessor. It sends each access to one of several places: the local RAM, a 64-byte boot ROM that can overlay the top of the address space, or a window of sixteen control registers at 0x00F0 to 0x00FF. It holds the control state behind that window and drives the static controls of three timers: enable, reload target and clock-speed select. It also pulses a clear to each timer whenever software reads that timer's output.

The register window gives access to several resources. It has an indirect address/data pair into a 128-entry sound-register file, whose upper address half is a read-only mirror. It has four byte-wide mailbox ports to a host processor, with separate latches for each direction. It also has two scratch bytes. Every bus write is passed on to RAM, even when it also hits a register. Registers that software can only write read back as zero.

A request is a single-cycle strobe. Writes take effect at the clock edge that ends the request cycle. Read data appears on `bus_rdata` in the following cycle and stays there until the next read. RAM is external and synchronous with one cycle of latency. The ROM and the sound-register file are read combinationally through address outputs.

Top module: `snd_bus_decoder`

## Requirements
- R1: A read of 0x00F0–0x00FF returns the register value selected by the low address nibble. A read of any other address (outside an active ROM overlay) asserts `ram_en` and returns `ram_rdata`. Data is valid on `bus_rdata` in the cycle after the request. Reads of the write-only offsets 0x0, 0x1, 0xA, 0xB and 0xC return 0x00.
- R2: While the ROM overlay is on, a read of 0xFFC0–0xFFFF drives `rom_addr` with address bits 5:0 and returns `rom_rdata`. While the overlay is off, such a read returns RAM data.
- R3: Every bus write asserts `ram_en` and `ram_we` in the request cycle, with `ram_addr` and `ram_wdata` equal to the bus address and data. This also holds for writes to the register window and to the ROM range.
- R4: A write to 0x00F0 loads `clk_speed` from data bits 7:6 only while `flag_p` is 0. While `flag_p` is 1 the write leaves `clk_speed` unchanged.
- R5: A write to 0x00F1 sets the ROM overlay enable from data bit 7 and `tmr_enable[2:0]` from data bits 2:0.
- R6: A write to 0x00F1 with data bit 4 set clears host input ports 0 and 1. Data bit 5 set clears input ports 2 and 3. In the same cycle, the clear wins over a host write to that port.
- R7: 0x00F2 is a read/write byte holding the sound-register index, and `snd_addr` carries its bits 6:0. A read of 0x00F3 returns `snd_rdata`. A write to 0x00F3 asserts `snd_we` with `snd_wdata` equal to the bus data only when index bit 7 is 0.
- R8: A read of 0x00F4+k (k = 0..3) returns host input port k, which the host loads through `host_wr[k]`/`host_wdata`. A write to 0x00F4+k loads output port k, presented on `port_out[8k+7:8k]`.
- R9: 0x00F8 and 0x00F9 are independent read/write scratch bytes.
- R10: A write to 0x00FA+k (k = 0..2) loads timer k's target, presented on `tmr_target[8k+7:8k]`.
- R11: A read of 0x00FD+k returns `tmr_out[4k+3:4k]` zero-extended. It pulses `tmr_clr[k]` during the request cycle. A write to 0x00FD–0x00FF pulses no clear and changes no register.
- R12: After reset the ROM overlay is on, and `bus_rdata`, `clk_speed`, `tmr_enable`, `tmr_target`, `snd_addr`, `port_out`, the scratch bytes and the input ports are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read request |
| flag_p | input | 1 | Processor direct-page flag; when 1, writes to the speed register are blocked |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after `ram_en` |
| rom_addr | output | 6 | Boot ROM index |
| rom_rdata | input | 8 | Boot ROM data for `rom_addr` |
| snd_addr | output | 7 | Sound-register file index |
| snd_we | output | 1 | Sound-register file write enable |
| snd_wdata | output | 8 | Sound-register file write data |
| snd_rdata | input | 8 | Sound-register file data at `snd_addr` |
| host_wr | input | 4 | Host write strobe per input port |
| host_wdata | input | 8 | Host write data |
| port_out | output | 32 | Output ports to the host, port k in bits 8k+7:8k |
| clk_speed | output | 2 | Clock-speed select |
| tmr_enable | output | 3 | Timer enables |
| tmr_target | output | 24 | Timer targets, timer k in bits 8k+7:8k |
| tmr_out | input | 12 | Timer output counters, timer k in bits 4k+3:4k |
| tmr_clr | output | 3 | Timer output clear pulses |

## Verification
The checker watches every cycle for the following. Each write reaches RAM unchanged. The speed register is locked while `flag_p` is high. Timer enables and the sound index load from the write data. A port-clearing control write leaves the cleared input ports at zero. Write-only registers read as zero. A timer clear pulse only ever comes with a read. The bench scenarios are the only place to show the behaviours that depend on history. Examples are the ROM overlay handing its range back to RAM once it is switched off, and the mirrored upper half of the sound index blocking a write. Another is the input-port clear winning over a host write in the same cycle. The last is an ignored write to a timer output register, which neither pulses a clear nor moves any state.

// File: rtl/snd_dec_pkg.sv
package snd_dec_pkg;

  // Register window offsets (low address nibble); fixed by software view.
  localparam logic [3:0] OFS_TEST = 4'h0;
  localparam logic [3:0] OFS_CTRL = 4'h1;
  localparam logic [3:0] OFS_SNDA = 4'h2;
  localparam logic [3:0] OFS_SNDD = 4'h3;
  localparam int         PORT_OFS = 4;

  // Bit positions inside the written bytes.
  localparam int SPD_HI       = 7;
  localparam int SPD_LO       = 6;
  localparam int CTRL_ROM_BIT = 7;
  localparam int CTRL_CLR_LO  = 4;
  localparam int CTRL_CLR_HI  = 5;

  typedef enum logic {
    SRC_LOCAL = 1'b0,
    SRC_RAM   = 1'b1
  } rd_src_e;

endpackage

// File: rtl/snd_rst_sync.sv
module snd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/snd_addr_dec.sv
module snd_addr_dec #(
  parameter int                ADDR_W   = 16,
  parameter int                ROM_AW   = 6,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'h00F0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rom_on,
  output logic              reg_hit,
  output logic              rom_hit,
  output logic [3:0]        ofs
);

  always_comb begin
    reg_hit = (addr[ADDR_W-1:4] == REG_BASE[ADDR_W-1:4]);
    rom_hit = rom_on && (&addr[ADDR_W-1:ROM_AW]);
    ofs     = addr[3:0];
  end

endmodule

// File: rtl/snd_ctrl_regs.sv
module snd_ctrl_regs
  import snd_dec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NPORT  = 4,
  parameter int NTMR   = 3,
  parameter int NSCR   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_stb,
  input  logic [3:0]                   ofs,
  input  logic [DATA_W-1:0]            wdata,
  input  logic                         flag_p,
  input  logic [NPORT-1:0]             host_wr,
  input  logic [DATA_W-1:0]            host_wdata,
  output logic [1:0]                   clk_speed,
  output logic                         rom_on,
  output logic [NTMR-1:0]              tmr_enable,
  output logic [NTMR-1:0][DATA_W-1:0]  tmr_target,
  output logic [DATA_W-1:0]            snd_index,
  output logic [NSCR-1:0][DATA_W-1:0]  scratch,
  output logic [NPORT-1:0][DATA_W-1:0] port_in,
  output logic [NPORT-1:0][DATA_W-1:0] port_out,
  output logic                         snd_we
);

  localparam int SCR_OFS = PORT_OFS + NPORT;
  localparam int TGT_OFS = SCR_OFS + NSCR;
  localparam int HALF    = NPORT / 2;

  logic [1:0]                   speed_q, speed_d;
  logic                         rom_q, rom_d;
  logic [NTMR-1:0]              ten_q, ten_d;
  logic [NTMR-1:0][DATA_W-1:0]  tgt_q, tgt_d;
  logic [DATA_W-1:0]            sidx_q, sidx_d;
  logic [NSCR-1:0][DATA_W-1:0]  scr_q, scr_d;
  logic [NPORT-1:0][DATA_W-1:0] pin_q, pin_d;
  logic [NPORT-1:0][DATA_W-1:0] pout_q, pout_d;
  logic                         wr_test, wr_ctrl, wr_sidx;
  logic                         pin_ce;

  // next-state logic
  always_comb begin
    speed_d = speed_q;
    rom_d   = rom_q;
    ten_d   = ten_q;
    tgt_d   = tgt_q;
    sidx_d  = sidx_q;
    scr_d   = scr_q;
    pin_d   = pin_q;
    pout_d  = pout_q;

    wr_test = wr_stb && (ofs == OFS_TEST);
    wr_ctrl = wr_stb && (ofs == OFS_CTRL);
    wr_sidx = wr_stb && (ofs == OFS_SNDA);

    if (wr_test && !flag_p) begin
      speed_d = wdata[SPD_HI:SPD_LO];
    end
    if (wr_ctrl) begin
      rom_d = wdata[CTRL_ROM_BIT];
      ten_d = wdata[NTMR-1:0];
    end
    if (wr_sidx) begin
      sidx_d = wdata;
    end

    for (int k = 0; k < NPORT; k++) begin
      if (host_wr[k]) begin
        pin_d[k] = host_wdata;
      end
      // control clear has priority over a simultaneous host load
      if (wr_ctrl && ((k < HALF) ? wdata[CTRL_CLR_LO] : wdata[CTRL_CLR_HI])) begin
        pin_d[k] = '0;
      end
      if (wr_stb && (ofs == 4'(PORT_OFS + k))) begin
        pout_d[k] = wdata;
      end
    end

    for (int k = 0; k < NSCR; k++) begin
      if (wr_stb && (ofs == 4'(SCR_OFS + k))) begin
        scr_d[k] = wdata;
      end
    end

    for (int k = 0; k < NTMR; k++) begin
      if (wr_stb && (ofs == 4'(TGT_OFS + k))) begin
        tgt_d[k] = wdata;
      end
    end
  end

  assign pin_ce = wr_ctrl || (|host_wr);

  // bus-written state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speed_q <= '0;
      rom_q   <= 1'b1;
      ten_q   <= '0;
      tgt_q   <= '0;
      sidx_q  <= '0;
      scr_q   <= '0;
      pout_q  <= '0;
    end else if (wr_stb) begin
      speed_q <= speed_d;
      rom_q   <= rom_d;
      ten_q   <= ten_d;
      tgt_q   <= tgt_d;
      sidx_q  <= sidx_d;
      scr_q   <= scr_d;
      pout_q  <= pout_d;
    end
  end

  // host input latches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= '0;
    end else if (pin_ce) begin
      pin_q <= pin_d;
    end
  end

  assign clk_speed  = speed_q;
  assign rom_on     = rom_q;
  assign tmr_enable = ten_q;
  assign tmr_target = tgt_q;
  assign snd_index  = sidx_q;
  assign scratch    = scr_q;
  assign port_in    = pin_q;
  assign port_out   = pout_q;
  // upper half of the index space is a read-only mirror
  assign snd_we     = wr_stb && (ofs == OFS_SNDD) && !sidx_q[DATA_W-1];

endmodule

// File: rtl/snd_read_path.sv
module snd_read_path
  import snd_dec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NPORT  = 4,
  parameter int NTMR   = 3,
  parameter int NSCR   = 2,
  parameter int TOUT_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_req,
  input  logic                         reg_hit,
  input  logic                         rom_hit,
  input  logic [3:0]                   ofs,
  input  logic [DATA_W-1:0]            snd_index,
  input  logic [DATA_W-1:0]            snd_rdata,
  input  logic [NPORT-1:0][DATA_W-1:0] port_in,
  input  logic [NSCR-1:0][DATA_W-1:0]  scratch,
  input  logic [NTMR-1:0][TOUT_W-1:0]  tmr_out,
  input  logic [DATA_W-1:0]            rom_rdata,
  input  logic [DATA_W-1:0]            ram_rdata,
  output logic [DATA_W-1:0]            bus_rdata,
  output logic [NTMR-1:0]              tmr_clr
);

  localparam int SCR_OFS  = PORT_OFS + NPORT;
  localparam int TOUT_OFS = SCR_OFS + NSCR + NTMR;

  rd_src_e           src_q, src_d;
  logic [DATA_W-1:0] hold_q, loc_val;

  always_comb begin
    loc_val = '0;
    if (reg_hit) begin
      if (ofs == OFS_SNDA) loc_val = snd_index;
      if (ofs == OFS_SNDD) loc_val = snd_rdata;
      for (int k = 0; k < NPORT; k++) begin
        if (ofs == 4'(PORT_OFS + k)) loc_val = port_in[k];
      end
      for (int k = 0; k < NSCR; k++) begin
        if (ofs == 4'(SCR_OFS + k)) loc_val = scratch[k];
      end
      for (int k = 0; k < NTMR; k++) begin
        if (ofs == 4'(TOUT_OFS + k)) loc_val = DATA_W'(tmr_out[k]);
      end
    end else if (rom_hit) begin
      loc_val = rom_rdata;
    end
    src_d = (reg_hit || rom_hit) ? SRC_LOCAL : SRC_RAM;
  end

  always_comb begin
    for (int k = 0; k < NTMR; k++) begin
      tmr_clr[k] = rd_req && reg_hit && (ofs == 4'(TOUT_OFS + k));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_LOCAL;
      hold_q <= '0;
    end else if (rd_req) begin
      src_q  <= src_d;
      hold_q <= loc_val;
    end
  end

  assign bus_rdata = (src_q == SRC_RAM) ? ram_rdata : hold_q;

endmodule

// File: rtl/snd_bus_decoder.sv
module snd_bus_decoder #(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter int                ROM_AW   = 6,
  parameter int                SND_AW   = 7,
  parameter int                NPORT    = 4,
  parameter int                NTMR     = 3,
  parameter int                NSCR     = 2,
  parameter int                TOUT_W   = 4,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'h00F0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_valid,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic                     flag_p,
  output logic                     ram_en,
  output logic                     ram_we,
  output logic [ADDR_W-1:0]        ram_addr,
  output logic [DATA_W-1:0]        ram_wdata,
  input  logic [DATA_W-1:0]        ram_rdata,
  output logic [ROM_AW-1:0]        rom_addr,
  input  logic [DATA_W-1:0]        rom_rdata,
  output logic [SND_AW-1:0]        snd_addr,
  output logic                     snd_we,
  output logic [DATA_W-1:0]        snd_wdata,
  input  logic [DATA_W-1:0]        snd_rdata,
  input  logic [NPORT-1:0]         host_wr,
  input  logic [DATA_W-1:0]        host_wdata,
  output logic [NPORT*DATA_W-1:0]  port_out,
  output logic [1:0]               clk_speed,
  output logic [NTMR-1:0]          tmr_enable,
  output logic [NTMR*DATA_W-1:0]   tmr_target,
  input  logic [NTMR*TOUT_W-1:0]   tmr_out,
  output logic [NTMR-1:0]          tmr_clr
);

  logic                         rst_sync_n;
  logic                         reg_hit, rom_hit, rom_on;
  logic [3:0]                   ofs;
  logic                         wr_stb, rd_req;
  logic [DATA_W-1:0]            snd_index;
  logic [NSCR-1:0][DATA_W-1:0]  scratch;
  logic [NPORT-1:0][DATA_W-1:0] port_in_arr, port_out_arr;
  logic [NTMR-1:0][DATA_W-1:0]  tgt_arr;
  logic [NTMR-1:0][TOUT_W-1:0]  tout_arr;
  logic [NPORT*DATA_W-1:0]      port_in_flat;

  snd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  snd_addr_dec #(
    .ADDR_W   (ADDR_W),
    .ROM_AW   (ROM_AW),
    .REG_BASE (REG_BASE)
  ) u_dec (
    .addr    (bus_addr),
    .rom_on  (rom_on),
    .reg_hit (reg_hit),
    .rom_hit (rom_hit),
    .ofs     (ofs)
  );

  assign wr_stb = bus_valid && bus_we && reg_hit;
  assign rd_req = bus_valid && !bus_we;

  snd_ctrl_regs #(
    .DATA_W (DATA_W),
    .NPORT  (NPORT),
    .NTMR   (NTMR),
    .NSCR   (NSCR)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_stb     (wr_stb),
    .ofs        (ofs),
    .wdata      (bus_wdata),
    .flag_p     (flag_p),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .clk_speed  (clk_speed),
    .rom_on     (rom_on),
    .tmr_enable (tmr_enable),
    .tmr_target (tgt_arr),
    .snd_index  (snd_index),
    .scratch    (scratch),
    .port_in    (port_in_arr),
    .port_out   (port_out_arr),
    .snd_we     (snd_we)
  );

  assign tout_arr = tmr_out;

  snd_read_path #(
    .DATA_W (DATA_W),
    .NPORT  (NPORT),
    .NTMR   (NTMR),
    .NSCR   (NSCR),
    .TOUT_W (TOUT_W)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_req    (rd_req),
    .reg_hit   (reg_hit),
    .rom_hit   (rom_hit),
    .ofs       (ofs),
    .snd_index (snd_index),
    .snd_rdata (snd_rdata),
    .port_in   (port_in_arr),
    .scratch   (scratch),
    .tmr_out   (tout_arr),
    .rom_rdata (rom_rdata),
    .ram_rdata (ram_rdata),
    .bus_rdata (bus_rdata),
    .tmr_clr   (tmr_clr)
  );

  // every write reaches RAM; reads go there only when nothing local claims them
  assign ram_en       = bus_valid && (bus_we || !(reg_hit || rom_hit));
  assign ram_we       = bus_valid && bus_we;
  assign ram_addr     = bus_addr;
  assign ram_wdata    = bus_wdata;
  assign rom_addr     = bus_addr[ROM_AW-1:0];
  assign snd_addr     = snd_index[SND_AW-1:0];
  assign snd_wdata    = bus_wdata;
  assign port_out     = port_out_arr;
  assign tmr_target   = tgt_arr;
  assign port_in_flat = port_in_arr;

endmodule

// File: rtl/snd_bus_decoder_chk.sv
module snd_bus_decoder_chk #(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter int                SND_AW   = 7,
  parameter int                NPORT    = 4,
  parameter int                NTMR     = 3,
  parameter int                TOUT_W   = 4,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'h00F0
) (
  input logic                    clk,
  input logic                    rst_sync_n,
  input logic                    bus_valid,
  input logic                    bus_we,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [DATA_W-1:0]       bus_wdata,
  input logic [DATA_W-1:0]       bus_rdata,
  input logic                    flag_p,
  input logic                    ram_en,
  input logic                    ram_we,
  input logic [ADDR_W-1:0]       ram_addr,
  input logic [DATA_W-1:0]       ram_wdata,
  input logic [SND_AW-1:0]       snd_addr,
  input logic [1:0]              clk_speed,
  input logic [NTMR-1:0]         tmr_enable,
  input logic [NTMR*TOUT_W-1:0]  tmr_out,
  input logic [NTMR-1:0]         tmr_clr,
  input logic [NPORT*DATA_W-1:0] port_in_flat
);

  logic wr_any, rd_any;
  logic wr_speed, wr_ctl, wr_idx, rd_wonly, rd_tout0;

  always_comb begin
    wr_any   = bus_valid && bus_we;
    rd_any   = bus_valid && !bus_we;
    wr_speed = wr_any && (bus_addr == REG_BASE);
    wr_ctl   = wr_any && (bus_addr == REG_BASE + 16'd1);
    wr_idx   = wr_any && (bus_addr == REG_BASE + 16'd2);
    rd_tout0 = rd_any && (bus_addr == REG_BASE + 16'd13);
    rd_wonly = rd_any && ((bus_addr == REG_BASE) || (bus_addr == REG_BASE + 16'd1) ||
               (bus_addr == REG_BASE + 16'd10) || (bus_addr == REG_BASE + 16'd11) ||
               (bus_addr == REG_BASE + 16'd12));
  end

  p_ram_write_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_any |-> (ram_en && ram_we && ram_addr == bus_addr && ram_wdata == bus_wdata));

  p_speed_locked_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_speed && flag_p) |=> $stable(clk_speed));

  p_speed_load_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_speed && !flag_p) |=> (clk_speed == $past(bus_wdata[7:6])));

  p_enable_load_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_ctl |=> (tmr_enable == $past(bus_wdata[NTMR-1:0])));

  p_port_clear_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_ctl && bus_wdata[4]) |=> (port_in_flat[2*DATA_W-1:0] == '0));

  p_index_load_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_idx |=> (snd_addr == $past(bus_wdata[SND_AW-1:0])));

  p_wonly_zero_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_wonly |=> (bus_rdata == '0));

  p_clr_on_read_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|tmr_clr) |-> rd_any);

  p_tout_value_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_tout0 |=> (bus_rdata == DATA_W'($past(tmr_out[TOUT_W-1:0]))));

endmodule

bind snd_bus_decoder snd_bus_decoder_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .SND_AW   (SND_AW),
  .NPORT    (NPORT),
  .NTMR     (NTMR),
  .TOUT_W   (TOUT_W),
  .REG_BASE (REG_BASE)
) chk_i (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .bus_valid    (bus_valid),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .flag_p       (flag_p),
  .ram_en       (ram_en),
  .ram_we       (ram_we),
  .ram_addr     (ram_addr),
  .ram_wdata    (ram_wdata),
  .snd_addr     (snd_addr),
  .clk_speed    (clk_speed),
  .tmr_enable   (tmr_enable),
  .tmr_out      (tmr_out),
  .tmr_clr      (tmr_clr),
  .port_in_flat (port_in_flat)
);

// File: tb/snd_bus_decoder_tb_top.sv
module snd_bus_decoder_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        flag_p = 1'b0;
  logic        ram_en, ram_we;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = '0;
  logic [5:0]  rom_addr;
  logic [7:0]  rom_rdata;
  logic [6:0]  snd_addr;
  logic        snd_we;
  logic [7:0]  snd_wdata;
  logic [7:0]  snd_rdata;
  logic [3:0]  host_wr = '0;
  logic [7:0]  host_wdata = '0;
  logic [31:0] port_out;
  logic [1:0]  clk_speed;
  logic [2:0]  tmr_enable;
  logic [23:0] tmr_target;
  logic [11:0] tmr_out = '0;
  logic [2:0]  tmr_clr;

  int total = 0;
  int bad = 0;

  // snapshots taken inside the request cycle
  logic        s_ram_we, s_ram_en, s_snd_we;
  logic [15:0] s_ram_addr;
  logic [7:0]  s_ram_wdata;
  logic [2:0]  s_clr;

  logic [7:0] ram_mem [0:2047];
  logic [7:0] snd_mem [0:127];

  always #(CLK_PERIOD/2) clk = ~clk;

  snd_bus_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flag_p(flag_p), .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .rom_addr(rom_addr),
    .rom_rdata(rom_rdata), .snd_addr(snd_addr), .snd_we(snd_we),
    .snd_wdata(snd_wdata), .snd_rdata(snd_rdata), .host_wr(host_wr),
    .host_wdata(host_wdata), .port_out(port_out), .clk_speed(clk_speed),
    .tmr_enable(tmr_enable), .tmr_target(tmr_target), .tmr_out(tmr_out),
    .tmr_clr(tmr_clr)
  );

  function automatic logic [10:0] ram_idx(input logic [15:0] a);
    return {a[15], a[9:0]};
  endfunction

  function automatic logic [7:0] rom_val(input logic [5:0] a);
    return {2'b10, a} ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) ram_mem[ram_idx(ram_addr)] <= ram_wdata;
      else        ram_rdata <= ram_mem[ram_idx(ram_addr)];
    end
  end

  assign rom_rdata = rom_val(rom_addr);
  assign snd_rdata = snd_mem[snd_addr];

  always @(posedge clk) begin
    if (snd_we) snd_mem[snd_addr] <= snd_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic snap();
    #1;
    s_ram_we    = ram_we;
    s_ram_en    = ram_en;
    s_ram_addr  = ram_addr;
    s_ram_wdata = ram_wdata;
    s_snd_we    = snd_we;
    s_clr       = tmr_clr;
  endtask

  task automatic bwr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    snap();
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic brd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    snap();
    @(negedge clk);
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic host_load(input logic [3:0] mask, input logic [7:0] d);
    @(negedge clk);
    host_wr = mask; host_wdata = d;
    @(negedge clk);
    host_wr = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R12 rdata", 32'(bus_rdata), 32'h0);
    chk("R12 speed", 32'(clk_speed), 32'h0);
    chk("R12 enable", 32'(tmr_enable), 32'h0);
    chk("R12 target", 32'(tmr_target), 32'h0);
    chk("R12 port_out", port_out, 32'h0);
    chk("R12 snd_addr", 32'(snd_addr), 32'h0);
    brd(16'h00F4, d); chk("R12 port_in0", 32'(d), 32'h0);
    brd(16'h00F9, d); chk("R12 scratch1", 32'(d), 32'h0);
    brd(16'hFFC5, d); chk("R12 rom on", 32'(d), 32'(rom_val(6'd5)));
  endtask

  task automatic t_ram();
    logic [7:0] d;
    bwr(16'h1234, 8'h5B);
    chk("R3 ram_we", 32'({s_ram_en, s_ram_we}), 32'h3);
    chk("R3 ram_addr", 32'(s_ram_addr), 32'h1234);
    chk("R3 ram_wdata", 32'(s_ram_wdata), 32'h5B);
    bwr(16'h0300, 8'h11);
    brd(16'h1234, d); chk("R1 ram read a", 32'(d), 32'h5B);
    chk("R1 ram_en on read", 32'(s_ram_en), 32'h1);
    brd(16'h0300, d); chk("R1 ram read b", 32'(d), 32'h11);
    bwr(16'h00F8, 8'h9C);
    chk("R3 reg write reaches ram", 32'({s_ram_we, s_ram_addr, s_ram_wdata}), {7'h0, 1'b1, 16'h00F8, 8'h9C});
  endtask

  task automatic t_rom();
    logic [7:0] d;
    bwr(16'hFFC5, 8'h77);
    chk("R3 rom range write", 32'(s_ram_we), 32'h1);
    brd(16'hFFFF, d); chk("R2 rom top", 32'(d), 32'(rom_val(6'h3F)));
    brd(16'hFFC5, d); chk("R2 rom still overlays", 32'(d), 32'(rom_val(6'd5)));
    bwr(16'h00F1, 8'h00);
    brd(16'hFFC5, d); chk("R2 rom off gives ram", 32'(d), 32'h77);
    bwr(16'h00F1, 8'h80);
    brd(16'hFFC5, d); chk("R2 rom back on", 32'(d), 32'(rom_val(6'd5)));
  endtask

  task automatic t_speed();
    logic [7:0] d;
    flag_p = 1'b1;
    bwr(16'h00F0, 8'hC0);
    chk("R4 locked by flag", 32'(clk_speed), 32'h0);
    flag_p = 1'b0;
    bwr(16'h00F0, 8'h80);
    chk("R4 speed load", 32'(clk_speed), 32'h2);
    brd(16'h00F0, d); chk("R1 speed reg reads zero", 32'(d), 32'h0);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    bwr(16'h00F1, 8'h85);
    chk("R5 enables", 32'(tmr_enable), 32'h5);
    brd(16'hFFC1, d); chk("R5 rom kept on", 32'(d), 32'(rom_val(6'd1)));
    brd(16'h00F1, d); chk("R1 ctrl reads zero", 32'(d), 32'h0);
  endtask

  task automatic t_ports();
    logic [7:0] d;
    for (int k = 0; k < 4; k++) host_load(4'(1 << k), 8'(8'h10 + k));
    for (int k = 0; k < 4; k++) begin
      brd(16'(16'h00F4 + k), d); chk("R8 host input read", 32'(d), 32'(8'h10 + k));
    end
    bwr(16'h00F5, 8'hAB);
    chk("R8 output port", port_out, 32'h0000AB00);
    brd(16'h00F5, d); chk("R8 in/out separate", 32'(d), 32'h11);
    bwr(16'h00F1, 8'h90);
    brd(16'h00F4, d); chk("R6 lo clear p0", 32'(d), 32'h0);
    brd(16'h00F5, d); chk("R6 lo clear p1", 32'(d), 32'h0);
    brd(16'h00F6, d); chk("R6 lo keeps p2", 32'(d), 32'h12);
    bwr(16'h00F1, 8'hA0);
    brd(16'h00F7, d); chk("R6 hi clear p3", 32'(d), 32'h0);
    host_load(4'b0001, 8'h44);
    brd(16'h00F4, d); chk("R8 reload p0", 32'(d), 32'h44);
    // same-cycle host load and clear
    @(negedge clk);
    host_wr = 4'b0010; host_wdata = 8'h55;
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = 16'h00F1; bus_wdata = 8'h90;
    @(negedge clk);
    host_wr = '0; bus_valid = 1'b0; bus_we = 1'b0;
    brd(16'h00F5, d); chk("R6 clear beats host", 32'(d), 32'h0);
  endtask

  task automatic t_sound();
    logic [7:0] d;
    bwr(16'h00F2, 8'h05);
    chk("R7 snd_addr", 32'(snd_addr), 32'h05);
    brd(16'h00F2, d); chk("R7 index read", 32'(d), 32'h05);
    brd(16'h00F3, d); chk("R7 data read", 32'(d), 32'h39);
    bwr(16'h00F3, 8'h66);
    chk("R7 write strobe", 32'(s_snd_we), 32'h1);
    brd(16'h00F3, d); chk("R7 data written", 32'(d), 32'h66);
    bwr(16'h00F2, 8'h85);
    brd(16'h00F3, d); chk("R7 mirror read", 32'(d), 32'h66);
    bwr(16'h00F3, 8'h99);
    chk("R7 mirror blocks strobe", 32'(s_snd_we), 32'h0);
    brd(16'h00F3, d); chk("R7 mirror write ignored", 32'(d), 32'h66);
    brd(16'h00F2, d); chk("R7 full index kept", 32'(d), 32'h85);
  endtask

  task automatic t_scratch();
    logic [7:0] d;
    bwr(16'h00F8, 8'hC3);
    bwr(16'h00F9, 8'h3D);
    brd(16'h00F8, d); chk("R9 scratch0", 32'(d), 32'hC3);
    brd(16'h00F9, d); chk("R9 scratch1", 32'(d), 32'h3D);
  endtask

  task automatic t_target();
    logic [7:0] d;
    bwr(16'h00FA, 8'h11);
    bwr(16'h00FB, 8'h22);
    bwr(16'h00FC, 8'h33);
    chk("R10 targets", 32'(tmr_target), 32'h00332211);
    brd(16'h00FB, d); chk("R1 target reads zero", 32'(d), 32'h0);
  endtask

  task automatic t_tout();
    logic [7:0] d;
    tmr_out = 12'h95C;
    brd(16'h00FD, d);
    chk("R11 t0 value", 32'(d), 32'h0C);
    chk("R11 t0 clear", 32'(s_clr), 32'h1);
    brd(16'h00FF, d);
    chk("R11 t2 value", 32'(d), 32'h09);
    chk("R11 t2 clear", 32'(s_clr), 32'h4);
    bwr(16'h00FE, 8'hFF);
    chk("R11 write no clear", 32'(s_clr), 32'h0);
    chk("R11 write no target change", 32'(tmr_target), 32'h00332211);
    brd(16'h00FE, d); chk("R11 t1 value after write", 32'(d), 32'h05);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) snd_mem[i] = 8'(i) ^ 8'h3C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_ram();
    t_rom();
    t_speed();
    t_ctrl();
    t_ports();
    t_sound();
    t_scratch();
    t_target();
    t_tout();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule